// File: doc/BRIEF.md
# Quad Depth Test Unit

This block runs the depth comparison for one 2x2 pixel quad per strobe. Each of the four lanes brings a fragment depth as an IEEE single-precision float in the range 0 to 1, a live bit, and the packed depth/stencil word already held in the framebuffer for that pixel. The float is scaled to an unsigned integer of `DEPTH_W` bits. That integer is compared with the low `DEPTH_W` bits of the framebuffer word under one of eight selectable functions. Lanes that fail the test are dropped from the live mask.

All results are registered one clock after the input strobe: the narrowed live mask, a per-lane pass mask and four write-back words. When depth writes are on, a surviving lane writes the new fragment depth into its word. A write-back enable tells the surrounding pipeline whether the words must be stored. The stencil byte in the top bits of each word is carried through unchanged. Stencil testing and memory access belong to neighbouring blocks.

Top module: `quad_depth_test`

## Requirements
- R1: A fragment depth is converted to trunc(f * (2^DEPTH_W - 1)). Negative inputs, either zero, NaN and denormals give 0. Inputs of 1.0 or more and +infinity give all ones.
- R2: The stored depth of a lane is the low DEPTH_W bits of its framebuffer word. The top WORD_W-DEPTH_W bits play no part in the comparison.
- R3: The code on `depthFunc` selects the pass condition, where frag is the converted fragment depth and stored is the stored depth: 0 never, 1 frag < stored, 2 equal, 3 frag <= stored, 4 frag > stored, 5 not equal, 6 frag >= stored, 7 always. `passMask` bit i is set when lane i meets the condition, whether or not the lane is live.
- R4: Code 0 gives `passMask` = 0 and `liveOut` = 0. Code 7 gives `passMask` all ones and `liveOut` equal to `liveIn`.
- R5: `liveOut` = `liveIn` AND `passMask`. A dead lane never becomes live again.
- R6: When `depthWriteEn` is set, the depth field of a lane's write-back word is the converted fragment depth if that lane's bit in `liveOut` is set, and the old stored depth otherwise. When `depthWriteEn` is clear, the depth field is the old stored depth in every lane.
- R7: Each write-back word is {old stencil bits [WORD_W-1:DEPTH_W], new depth}. Lane i occupies bits [i*WORD_W +: WORD_W] on every packed bus, and mask bit i belongs to lane i.
- R8: `wbEn` = `depthWriteEn` OR (`stencilWrMaskFront` != 0) OR (`stencilWrMaskBack` != 0).
- R9: `outValid` rises exactly one clock after a clock edge that sees `inValid` high. Without a strobe, all result outputs hold their values.
- R10: During reset, `outValid`, `liveOut`, `passMask`, `wbWord` and `wbEn` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Quad input strobe |
| depthFunc | input | 3 | Compare function code (R3) |
| depthWriteEn | input | 1 | Depth write enable |
| stencilWrMaskFront | input | WORD_W-DEPTH_W | Front stencil write mask |
| stencilWrMaskBack | input | WORD_W-DEPTH_W | Back stencil write mask |
| fragDepth | input | LANES*32 | Fragment depths, single-precision floats |
| liveIn | input | LANES | Incoming live mask |
| fbWord | input | LANES*WORD_W | Framebuffer depth/stencil words |
| outValid | output | 1 | Result strobe |
| liveOut | output | LANES | Updated live mask |
| passMask | output | LANES | Per-lane depth-pass mask |
| wbWord | output | LANES*WORD_W | Write-back depth/stencil words |
| wbEn | output | 1 | Write-back required |

## Verification
Two functions resolve in the same cycle: the live-mask update and the depth merge for write-back. A lane that arrives live but fails the test must keep its old depth, even with depth writes enabled. A lane that arrives dead but would pass must keep its old depth too. The stimulus table mixes live masks with every function and toggles the write enable. Each write-back word is judged against the expected updated mask, never against the incoming one. Back-to-back strobes check that consecutive quads do not leak into each other.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int FLOAT_W = 32;

  typedef enum logic [2:0] {
    FN_NEVER   = 3'd0,
    FN_LESS    = 3'd1,
    FN_EQUAL   = 3'd2,
    FN_LEQUAL  = 3'd3,
    FN_GREATER = 3'd4,
    FN_NOTEQ   = 3'd5,
    FN_GEQUAL  = 3'd6,
    FN_ALWAYS  = 3'd7
  } depthFunc_e;

  typedef struct packed {
    logic capture;
  } qdtStrobe_t;
endpackage

// File: rtl/qdt_f2d.sv
module qdt_f2d #(
  parameter int DEPTH_W = 24
) (
  input  logic [31:0]        fBits,
  output logic [DEPTH_W-1:0] depth
);
  localparam int MAN_W = 24;
  localparam int PW    = MAN_W + DEPTH_W;
  localparam logic [DEPTH_W-1:0] MAXD = {DEPTH_W{1'b1}};

  logic          sgn;
  logic [7:0]    ex;
  logic [22:0]   frac;
  logic [MAN_W-1:0] man;
  logic [7:0]    sh;
  logic [PW-1:0] prod;

  always_comb begin
    sgn  = fBits[31];
    ex   = fBits[30:23];
    frac = fBits[22:0];
    man  = {|ex, frac};
    sh   = 8'd150 - ex;
    prod = PW'(man) * PW'(MAXD);
    if (ex == 8'hFF)       depth = (frac == '0 && !sgn) ? MAXD : '0;
    else if (sgn)          depth = '0;
    else if (ex >= 8'd127) depth = MAXD;
    else if (ex == 8'd0)   depth = '0;
    else                   depth = DEPTH_W'(prod >> sh);
  end
endmodule

// File: rtl/qdt_ctrl.sv
module qdt_ctrl
  import qdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output qdtStrobe_t strobe,
  output logic       outValid
);
  always_comb strobe.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/qdt_datapath.sv
module qdt_datapath
  import qdt_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WORD_W  = 32,
  parameter int DEPTH_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  qdtStrobe_t                strobe,
  input  logic [2:0]                depthFunc,
  input  logic                      depthWriteEn,
  input  logic [WORD_W-DEPTH_W-1:0] stencilWrMaskFront,
  input  logic [WORD_W-DEPTH_W-1:0] stencilWrMaskBack,
  input  logic [LANES*FLOAT_W-1:0]  fragDepth,
  input  logic [LANES-1:0]          liveIn,
  input  logic [LANES*WORD_W-1:0]   fbWord,
  output logic [LANES-1:0]          liveOut,
  output logic [LANES-1:0]          passMask,
  output logic [LANES*WORD_W-1:0]   wbWord,
  output logic                      wbEn
);
  localparam int SW = WORD_W - DEPTH_W;

  logic [DEPTH_W-1:0]      fragI  [LANES];
  logic [LANES-1:0]        passC;
  logic [LANES-1:0]        liveC;
  logic [LANES*WORD_W-1:0] wbC;
  depthFunc_e              fn;

  assign fn = depthFunc_e'(depthFunc);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qdt_f2d #(.DEPTH_W(DEPTH_W)) u_f2d (
      .fBits(fragDepth[g*FLOAT_W +: FLOAT_W]),
      .depth(fragI[g])
    );

    logic [DEPTH_W-1:0] stored;
    logic [SW-1:0]      stencil;
    logic               eqL, fgtL, sgtL;

    always_comb begin
      stored  = fbWord[g*WORD_W +: DEPTH_W];
      stencil = fbWord[g*WORD_W + DEPTH_W +: SW];
      eqL     = (fragI[g] == stored);
      fgtL    = (fragI[g] > stored);
      sgtL    = (stored > fragI[g]);
      unique case (fn)
        FN_NEVER:   passC[g] = 1'b0;
        FN_LESS:    passC[g] = sgtL;
        FN_EQUAL:   passC[g] = eqL;
        FN_LEQUAL:  passC[g] = ~fgtL;
        FN_GREATER: passC[g] = fgtL;
        FN_NOTEQ:   passC[g] = ~eqL;
        FN_GEQUAL:  passC[g] = ~sgtL;
        default:    passC[g] = 1'b1;
      endcase
      liveC[g] = liveIn[g] & passC[g];
      wbC[g*WORD_W +: WORD_W] =
        {stencil, (depthWriteEn && liveC[g]) ? fragI[g] : stored};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveOut  <= '0;
      passMask <= '0;
      wbWord   <= '0;
      wbEn     <= 1'b0;
    end else if (strobe.capture) begin
      liveOut  <= liveC;
      passMask <= passC;
      wbWord   <= wbC;
      wbEn     <= depthWriteEn | (|stencilWrMaskFront) | (|stencilWrMaskBack);
    end
  end
endmodule

// File: rtl/quad_depth_test.sv
module quad_depth_test
  import qdt_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WORD_W  = 32,
  parameter int DEPTH_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [2:0]                depthFunc,
  input  logic                      depthWriteEn,
  input  logic [WORD_W-DEPTH_W-1:0] stencilWrMaskFront,
  input  logic [WORD_W-DEPTH_W-1:0] stencilWrMaskBack,
  input  logic [LANES*32-1:0]       fragDepth,
  input  logic [LANES-1:0]          liveIn,
  input  logic [LANES*WORD_W-1:0]   fbWord,
  output logic                      outValid,
  output logic [LANES-1:0]          liveOut,
  output logic [LANES-1:0]          passMask,
  output logic [LANES*WORD_W-1:0]   wbWord,
  output logic                      wbEn
);
  qdtStrobe_t strobe;

  qdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  qdt_datapath #(.LANES(LANES), .WORD_W(WORD_W), .DEPTH_W(DEPTH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .depthFunc(depthFunc), .depthWriteEn(depthWriteEn),
    .stencilWrMaskFront(stencilWrMaskFront), .stencilWrMaskBack(stencilWrMaskBack),
    .fragDepth(fragDepth), .liveIn(liveIn), .fbWord(fbWord),
    .liveOut(liveOut), .passMask(passMask), .wbWord(wbWord), .wbEn(wbEn)
  );
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int LANES   = 4,
  parameter int WORD_W  = 32,
  parameter int DEPTH_W = 24
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic [2:0]                depthFunc,
  input logic                      depthWriteEn,
  input logic [WORD_W-DEPTH_W-1:0] stencilWrMaskFront,
  input logic [WORD_W-DEPTH_W-1:0] stencilWrMaskBack,
  input logic [LANES*32-1:0]       fragDepth,
  input logic [LANES-1:0]          liveIn,
  input logic [LANES*WORD_W-1:0]   fbWord,
  input logic                      outValid,
  input logic [LANES-1:0]          liveOut,
  input logic [LANES-1:0]          passMask,
  input logic [LANES*WORD_W-1:0]   wbWord,
  input logic                      wbEn
);
  function automatic logic [LANES*WORD_W-1:0] mkStMask();
    logic [LANES*WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      m[i*WORD_W + DEPTH_W +: WORD_W-DEPTH_W] = '1;
    return m;
  endfunction

  localparam logic [LANES*WORD_W-1:0] ST_MASK = mkStMask();

  // R9
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid));

  // R5
  no_revive_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (liveOut & ~$past(liveIn)) == '0);

  // R3
  live_in_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (liveOut & ~passMask) == '0);

  // R4
  never_kills_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(depthFunc) == 3'd0 |-> liveOut == '0 && passMask == '0);

  // R4
  always_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(depthFunc) == 3'd7 |-> liveOut == $past(liveIn) && passMask == '1);

  // R7
  stencil_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (wbWord & ST_MASK) == ($past(fbWord) & ST_MASK));

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(depthWriteEn) |-> (wbWord & ~ST_MASK) == ($past(fbWord) & ~ST_MASK));

  // R8
  wb_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> wbEn == ($past(depthWriteEn) | (|$past(stencilWrMaskFront)) | (|$past(stencilWrMaskBack))));
endmodule

bind quad_depth_test qdt_checker #(.LANES(LANES), .WORD_W(WORD_W), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .depthFunc(depthFunc),
  .depthWriteEn(depthWriteEn), .stencilWrMaskFront(stencilWrMaskFront),
  .stencilWrMaskBack(stencilWrMaskBack), .fragDepth(fragDepth), .liveIn(liveIn),
  .fbWord(fbWord), .outValid(outValid), .liveOut(liveOut), .passMask(passMask),
  .wbWord(wbWord), .wbEn(wbEn)
);

// File: tb/quad_depth_test_tb.sv
`timescale 1ns/1ps
module quad_depth_test_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [2:0]   depthFunc;
  logic         depthWriteEn;
  logic [7:0]   smF, smB;
  logic [127:0] fragDepth;
  logic [3:0]   liveIn;
  logic [127:0] fbWord;
  logic         outValid;
  logic [3:0]   liveOut, passMask;
  logic [127:0] wbWord;
  logic         wbEn;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  always #5 clk = ~clk;

  quad_depth_test u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .depthFunc(depthFunc),
    .depthWriteEn(depthWriteEn), .stencilWrMaskFront(smF), .stencilWrMaskBack(smB),
    .fragDepth(fragDepth), .liveIn(liveIn), .fbWord(fbWord),
    .outValid(outValid), .liveOut(liveOut), .passMask(passMask),
    .wbWord(wbWord), .wbEn(wbEn)
  );

  typedef struct packed {
    logic [2:0] fn;
    logic [3:0] live;
    logic       dwe;
    logic [3:0] expLive;
    logic [3:0] expPass;
  } vec_t;

  // frags all 0.5 -> 0x7FFFFF; stored: lane0 eq, lane1 above, lane2 below, lane3 eq
  localparam vec_t VECS [16] = '{
    '{3'd0, 4'hF, 1'b1, 4'h0, 4'h0}, '{3'd1, 4'hF, 1'b0, 4'h2, 4'h2},
    '{3'd2, 4'hF, 1'b1, 4'h9, 4'h9}, '{3'd3, 4'hF, 1'b0, 4'hB, 4'hB},
    '{3'd4, 4'hF, 1'b1, 4'h4, 4'h4}, '{3'd5, 4'hF, 1'b0, 4'h6, 4'h6},
    '{3'd6, 4'hF, 1'b1, 4'hD, 4'hD}, '{3'd7, 4'hF, 1'b0, 4'hF, 4'hF},
    '{3'd0, 4'h5, 1'b0, 4'h0, 4'h0}, '{3'd1, 4'h5, 1'b1, 4'h0, 4'h2},
    '{3'd2, 4'h5, 1'b0, 4'h1, 4'h9}, '{3'd3, 4'h5, 1'b1, 4'h1, 4'hB},
    '{3'd4, 4'h5, 1'b0, 4'h4, 4'h4}, '{3'd5, 4'h5, 1'b1, 4'h4, 4'h6},
    '{3'd6, 4'h5, 1'b0, 4'h5, 4'hD}, '{3'd7, 4'h5, 1'b1, 4'h5, 4'hF}
  };

  localparam logic [127:0] FB_STD   = {32'h567FFFFF, 32'h347FFFFE, 32'h12800000, 32'hAB7FFFFF};
  localparam logic [127:0] FRAG_HLF = {4{32'h3F000000}};

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] fn, logic [3:0] live, logic dwe, logic [7:0] a,
                       logic [7:0] b, logic [127:0] frag, logic [127:0] fb);
    @(negedge clk);
    inValid = 1'b1; depthFunc = fn; liveIn = live; depthWriteEn = dwe;
    smF = a; smB = b; fragDepth = frag; fbWord = fb;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; depthFunc = '0; depthWriteEn = 1'b0;
    smF = '0; smB = '0; fragDepth = '0; liveIn = '0; fbWord = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 outValid", 128'(outValid), 128'(0));
    chk("R10 liveOut", 128'(liveOut), 128'(0));
    chk("R10 passMask", 128'(passMask), 128'(0));
    chk("R10 wbWord", wbWord, 128'(0));
    chk("R10 wbEn", 128'(wbEn), 128'(0));
    rstN = 1'b1;

    // R3 R4 R5 R6 R7: table walk
    for (int v = 0; v < 16; v++) begin
      logic [127:0] expWb;
      apply(VECS[v].fn, VECS[v].live, VECS[v].dwe, 8'h0, 8'h0, FRAG_HLF, FB_STD);
      expWb = FB_STD;
      for (int l = 0; l < 4; l++)
        if (VECS[v].dwe && VECS[v].expLive[l]) expWb[l*32 +: 24] = 24'h7FFFFF;
      chk("R9 outValid", 128'(outValid), 128'(1));
      chk("R3 passMask", 128'(passMask), 128'(VECS[v].expPass));
      chk("R5 liveOut", 128'(liveOut), 128'(VECS[v].expLive));
      chk("R6 R7 wbWord", wbWord, expWb);
      chk("R8 wbEn dwe", 128'(wbEn), 128'(VECS[v].dwe));
    end

    // R9: no strobe, outputs hold
    @(negedge clk);
    chk("R9 outValid idle", 128'(outValid), 128'(0));
    chk("R9 liveOut held", 128'(liveOut), 128'(4'h5));

    // R1: conversion corners, ALWAYS + write, stencil bytes 0x11..0x44
    apply(3'd7, 4'hF, 1'b1, 8'h0, 8'h0,
          {32'hBF000000, 32'h40000000, 32'h3F800000, 32'h00000000},
          {32'h44000005, 32'h33000004, 32'h22000003, 32'h11000002});
    chk("R1 sat/zero", wbWord, {32'h44000000, 32'h33FFFFFF, 32'h22FFFFFF, 32'h11000000});
    apply(3'd7, 4'hF, 1'b1, 8'h0, 8'h0,
          {32'h7F800000, 32'h7FC00000, 32'h3F400000, 32'h3E800000},
          {32'h44000005, 32'h33000004, 32'h22000003, 32'h11000002});
    chk("R1 fractions/nan/inf", wbWord, {32'h44FFFFFF, 32'h33000000, 32'h22BFFFFF, 32'h113FFFFF});
    apply(3'd7, 4'hF, 1'b1, 8'h0, 8'h0,
          {32'h33800000, 32'h80000000, 32'h00000001, 32'h3F7FFFFF},
          {32'h44000005, 32'h33000004, 32'h22000003, 32'h11000002});
    chk("R1 truncation/denorm", wbWord, {32'h44000000, 32'h33000000, 32'h22000000, 32'h11FFFFFE});

    // R2: stencil byte differs but low bits equal -> EQUAL passes all
    apply(3'd2, 4'hF, 1'b0, 8'h0, 8'h0, FRAG_HLF,
          {32'hFF7FFFFF, 32'h007FFFFF, 32'h5A7FFFFF, 32'hA57FFFFF});
    chk("R2 stencil ignored", 128'(passMask), 128'(4'hF));

    // R8: stencil masks alone enable write-back
    apply(3'd7, 4'hF, 1'b0, 8'h00, 8'h01, FRAG_HLF, FB_STD);
    chk("R8 back mask", 128'(wbEn), 128'(1));
    chk("R6 no depth write", wbWord, FB_STD);
    apply(3'd7, 4'hF, 1'b0, 8'h80, 8'h00, FRAG_HLF, FB_STD);
    chk("R8 front mask", 128'(wbEn), 128'(1));
    apply(3'd7, 4'hF, 1'b0, 8'h00, 8'h00, FRAG_HLF, FB_STD);
    chk("R8 none", 128'(wbEn), 128'(0));

    // R9 R5: back-to-back strobes
    @(negedge clk);
    inValid = 1'b1; depthFunc = 3'd2; liveIn = 4'hF; depthWriteEn = 1'b1;
    fragDepth = FRAG_HLF; fbWord = FB_STD;
    @(negedge clk);
    chk("R9 b2b first", 128'(liveOut), 128'(4'h9));
    depthFunc = 3'd5; liveIn = 4'hE;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 b2b second", 128'(liveOut), 128'(4'h6));
    chk("R6 b2b wb", wbWord, {32'h567FFFFF, 32'h347FFFFF, 32'h127FFFFF, 32'hAB7FFFFF});
    @(negedge clk);
    chk("R9 b2b drop", 128'(outValid), 128'(0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule